// File: doc/BRIEF.md
# Supervisor User-Page Access Guard

This block sits after address translation and rules on a single load or store: may it proceed, or must it raise a page fault? It works out the privilege the access really runs at, applies the user-page rule tied to the SUM control bit, and then checks the read or write permission of the leaf page-table entry. It answers in the same cycle. When the access is refused, it gives the trap cause that belongs to the access type.

The block also holds the SUM bit of the machine status word. Software can write that bit, set it or clear it through a small CSR-style operation port. Kernels open a short window with SUM=1 while they copy to or from user buffers. They then close it again. For that reason the bit changes often and costs nothing to flip. If supervisor mode is absent, or the translation-mode field is hardwired to zero, the bit is locked at 0.

Top module: `sum_access_guard`

## Requirements
- R1: SUM is held at bit 18 of `status_rdata` (mask 0x40000); every other bit reads 0. It resets to 0. `csr_op` encodes 0 = hold, 1 = write (SUM takes `sum_wdata`), 2 = set (SUM becomes 1 if `sum_wdata`=1), 3 = clear (SUM becomes 0 if `sum_wdata`=1). The new value is visible from the clock edge that takes the operation.
- R2: With paging on and an effective privilege of supervisor, an access to a page with U=1 faults while SUM=0.
- R3: With paging on and an effective privilege of supervisor, an access to a page with U=1 is allowed while SUM=1, provided the R/W permission holds.
- R4: With `paging_on`=0, no access faults, whatever the privilege, SUM and page bits.
- R5: An access whose effective privilege is machine (`cur_priv`=3 with MPRV=0, or MPRV=1 with MPP=3) is always allowed.
- R6: MPRV=1 replaces the privilege with MPP only when `cur_priv`=3. With MPP=1 the SUM rule applies. MPRV has no effect in user or supervisor mode.
- R7: With paging on and an effective privilege of user (encoding 0, or the reserved encoding 2), an access to a page with U=0 faults whatever SUM holds.
- R8: With paging on and a non-machine effective privilege, a load needs R=1 and a store needs W=1; otherwise it faults.
- R9: `fault_cause` is 13 for a refused load, 15 for a refused store, and 0 otherwise. `acc_ok` and `acc_fault` are both 0 when `acc_valid`=0.
- R10: When S_MODE_PRESENT=0 or SATP_MODE_ZERO=1, SUM reads 0 and every write operation is ignored, so supervisor accesses to U=1 pages fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_op | input | 2 | Status operation: hold, write, set, clear |
| sum_wdata | input | 1 | SUM bit of the written operand |
| status_rdata | output | XLEN | Machine status word view (SUM only) |
| cur_priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| mprv | input | 1 | Modify-privilege control |
| mpp | input | 2 | Previous privilege field |
| paging_on | input | 1 | Page-based translation in effect |
| pte_u | input | 1 | Leaf entry user bit |
| pte_r | input | 1 | Leaf entry read bit |
| pte_w | input | 1 | Leaf entry write bit |
| acc_valid | input | 1 | Access present |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_ok | output | 1 | Access allowed |
| acc_fault | output | 1 | Access refused |
| fault_cause | output | 5 | Trap cause when refused |

## Verification
The bench targets the MPRV path from machine mode with MPP set to supervisor. A design that read the raw privilege there would let user pages through even though SUM=0. It also sets and clears SUM with operands whose SUM bit is 0. An engine that treated set or clear like a plain write would change the bit when it should not. It crosses U=1 with SUM=1 while R or W is missing, so a design that let SUM override the permission check gets caught. It also builds a second instance with supervisor mode absent: if SUM can still be written there, supervisor accesses to user pages would be allowed.

// File: rtl/sum_access_guard.sv
module sum_access_guard #(
  parameter int XLEN           = 64,
  parameter int SUM_BIT        = 18,
  parameter int CAUSE_W        = 5,
  parameter bit S_MODE_PRESENT = 1'b1,
  parameter bit SATP_MODE_ZERO = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         csr_op,
  input  logic               sum_wdata,
  output logic [XLEN-1:0]    status_rdata,
  input  logic [1:0]         cur_priv,
  input  logic               mprv,
  input  logic [1:0]         mpp,
  input  logic               paging_on,
  input  logic               pte_u,
  input  logic               pte_r,
  input  logic               pte_w,
  input  logic               acc_valid,
  input  logic               acc_store,
  output logic               acc_ok,
  output logic               acc_fault,
  output logic [CAUSE_W-1:0] fault_cause
);
  localparam bit SUM_WRITABLE = S_MODE_PRESENT && !SATP_MODE_ZERO;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_SET   = 2'd2;
  localparam logic [1:0] OP_CLEAR = 2'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD_PF  = CAUSE_W'(13);
  localparam logic [CAUSE_W-1:0] CAUSE_STORE_PF = CAUSE_W'(15);

  logic sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    case (csr_op)
      OP_WRITE: sum_d = sum_wdata;
      OP_SET:   if (sum_wdata) sum_d = 1'b1;
      OP_CLEAR: if (sum_wdata) sum_d = 1'b0;
      default:  sum_d = sum_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sum_q <= 1'b0;
    else        sum_q <= SUM_WRITABLE ? sum_d : 1'b0;
  end

  always_comb begin
    status_rdata = '0;
    status_rdata[SUM_BIT] = sum_q;
  end

  logic [1:0] eff_priv;
  logic       eff_m, eff_s, eff_u;
  logic       u_viol, perm_viol, checked, refuse;

  assign eff_priv  = (cur_priv == PRIV_M && mprv) ? mpp : cur_priv;
  assign eff_m     = (eff_priv == PRIV_M);
  assign eff_s     = (eff_priv == PRIV_S);
  assign eff_u     = !eff_m && !eff_s;
  assign checked   = paging_on && !eff_m;
  assign u_viol    = eff_u ? !pte_u : (eff_s && pte_u && !sum_q);
  assign perm_viol = acc_store ? !pte_w : !pte_r;
  assign refuse    = checked && (u_viol || perm_viol);

  assign acc_fault   = acc_valid && refuse;
  assign acc_ok      = acc_valid && !refuse;
  assign fault_cause = !acc_fault ? '0 : (acc_store ? CAUSE_STORE_PF : CAUSE_LOAD_PF);
endmodule

// File: rtl/sum_access_guard_chk.sv
module sum_access_guard_chk #(
  parameter int XLEN           = 64,
  parameter int SUM_BIT        = 18,
  parameter int CAUSE_W        = 5,
  parameter bit S_MODE_PRESENT = 1'b1,
  parameter bit SATP_MODE_ZERO = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         csr_op,
  input logic               sum_wdata,
  input logic [XLEN-1:0]    status_rdata,
  input logic [1:0]         cur_priv,
  input logic               mprv,
  input logic [1:0]         mpp,
  input logic               paging_on,
  input logic               pte_u,
  input logic               acc_valid,
  input logic               acc_store,
  input logic               acc_ok,
  input logic               acc_fault,
  input logic [CAUSE_W-1:0] fault_cause
);
  localparam bit WR = S_MODE_PRESENT && !SATP_MODE_ZERO;

  // R1
  sum_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WR && csr_op == 2'd1) |=> (status_rdata[SUM_BIT] == $past(sum_wdata)));

  // R1
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_op == 2'd0) |=> $stable(status_rdata));

  // R10
  sum_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !WR |-> (status_rdata == '0));

  // R2
  sum_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && paging_on && pte_u && !status_rdata[SUM_BIT] &&
     ((cur_priv == 2'd1 && !mprv) || (cur_priv == 2'd1) ||
      (cur_priv == 2'd3 && mprv && mpp == 2'd1))) |-> acc_fault);

  // R4
  paging_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !paging_on) |-> acc_ok);

  // R5
  machine_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cur_priv == 2'd3 && !mprv) |-> acc_ok);

  // R9
  cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> (fault_cause == (acc_store ? 5'd15 : 5'd13)));

  // R9
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({acc_ok, acc_fault}) == (acc_valid ? 1 : 0));
endmodule

bind sum_access_guard sum_access_guard_chk #(
  .XLEN(XLEN), .SUM_BIT(SUM_BIT), .CAUSE_W(CAUSE_W),
  .S_MODE_PRESENT(S_MODE_PRESENT), .SATP_MODE_ZERO(SATP_MODE_ZERO)
) chk_i (
  .clk(clk), .rst_n(rst_n), .csr_op(csr_op), .sum_wdata(sum_wdata),
  .status_rdata(status_rdata), .cur_priv(cur_priv), .mprv(mprv), .mpp(mpp),
  .paging_on(paging_on), .pte_u(pte_u), .acc_valid(acc_valid),
  .acc_store(acc_store), .acc_ok(acc_ok), .acc_fault(acc_fault),
  .fault_cause(fault_cause)
);

// File: tb/sum_access_guard_tb_top.sv
module sum_access_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] csr_op = 2'd0;
  logic sum_wdata = 1'b0;
  logic [1:0] cur_priv = 2'd0, mpp = 2'd0;
  logic mprv = 1'b0, paging_on = 1'b0;
  logic pte_u = 1'b0, pte_r = 1'b0, pte_w = 1'b0;
  logic acc_valid = 1'b0, acc_store = 1'b0;

  logic [63:0] rd_a, rd_b;
  logic ok_a, flt_a, ok_b, flt_b;
  logic [4:0] cause_a, cause_b;

  int checks = 0;
  int errors = 0;

  sum_access_guard dut_i (
    .clk(clk), .rst_n(rst_n), .csr_op(csr_op), .sum_wdata(sum_wdata),
    .status_rdata(rd_a), .cur_priv(cur_priv), .mprv(mprv), .mpp(mpp),
    .paging_on(paging_on), .pte_u(pte_u), .pte_r(pte_r), .pte_w(pte_w),
    .acc_valid(acc_valid), .acc_store(acc_store),
    .acc_ok(ok_a), .acc_fault(flt_a), .fault_cause(cause_a));

  sum_access_guard #(.S_MODE_PRESENT(1'b0)) dut_nos_i (
    .clk(clk), .rst_n(rst_n), .csr_op(csr_op), .sum_wdata(sum_wdata),
    .status_rdata(rd_b), .cur_priv(cur_priv), .mprv(mprv), .mpp(mpp),
    .paging_on(paging_on), .pte_u(pte_u), .pte_r(pte_r), .pte_w(pte_w),
    .acc_valid(acc_valid), .acc_store(acc_store),
    .acc_ok(ok_b), .acc_fault(flt_b), .fault_cause(cause_b));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic csr(input logic [1:0] op, input logic bitv);
    @(negedge clk); csr_op = op; sum_wdata = bitv;
    @(negedge clk); csr_op = 2'd0; sum_wdata = 1'b0;
  endtask

  task automatic acc(input logic [1:0] pv, input logic mp, input logic [1:0] pp,
                     input logic pg, input logic u, input logic r, input logic w,
                     input logic st);
    @(negedge clk);
    cur_priv = pv; mprv = mp; mpp = pp; paging_on = pg;
    pte_u = u; pte_r = r; pte_w = w; acc_store = st; acc_valid = 1'b1;
    #1;
  endtask

  task automatic expect_acc(input string req, input logic fault);
    chk({req, " fault"}, {63'd0, flt_a}, {63'd0, fault});
    chk({req, " ok"}, {63'd0, ok_a}, {63'd0, !fault});
  endtask

  task automatic t_reset;
    chk("R1 reset status", rd_a, 64'd0);
    chk("R9 idle ok", {63'd0, ok_a}, 64'd0);
    chk("R9 idle fault", {63'd0, flt_a}, 64'd0);
    chk("R9 idle cause", {59'd0, cause_a}, 64'd0);
  endtask

  task automatic t_csr_ops;
    csr(2'd1, 1'b1); chk("R1 write 1", rd_a, 64'h40000);
    csr(2'd3, 1'b0); chk("R1 clear with 0 no effect", rd_a, 64'h40000);
    csr(2'd3, 1'b1); chk("R1 clear", rd_a, 64'd0);
    csr(2'd2, 1'b0); chk("R1 set with 0 no effect", rd_a, 64'd0);
    csr(2'd2, 1'b1); chk("R1 set", rd_a, 64'h40000);
    csr(2'd1, 1'b0); chk("R1 write 0", rd_a, 64'd0);
  endtask

  task automatic t_super_sum;
    csr(2'd1, 1'b0);
    acc(2'd1, 0, 2'd0, 1, 1, 1, 1, 0); expect_acc("R2 S load U page SUM0", 1);
    chk("R9 load cause", {59'd0, cause_a}, 64'd13);
    acc(2'd1, 0, 2'd0, 1, 1, 1, 1, 1); expect_acc("R2 S store U page SUM0", 1);
    chk("R9 store cause", {59'd0, cause_a}, 64'd15);
    acc(2'd1, 0, 2'd0, 1, 0, 1, 1, 0); expect_acc("R2 S load S page", 0);
    chk("R9 no-fault cause", {59'd0, cause_a}, 64'd0);
    csr(2'd2, 1'b1);
    acc(2'd1, 0, 2'd0, 1, 1, 1, 1, 0); expect_acc("R3 S load U page SUM1", 0);
    acc(2'd1, 0, 2'd0, 1, 1, 1, 1, 1); expect_acc("R3 S store U page SUM1", 0);
    csr(2'd3, 1'b1);
  endtask

  task automatic t_paging_off;
    acc(2'd1, 0, 2'd0, 0, 1, 0, 0, 1); expect_acc("R4 S no paging", 0);
    acc(2'd0, 0, 2'd0, 0, 0, 0, 0, 0); expect_acc("R4 U no paging", 0);
  endtask

  task automatic t_machine;
    acc(2'd3, 0, 2'd1, 1, 1, 0, 0, 1); expect_acc("R5 M bypass", 0);
    acc(2'd3, 1, 2'd3, 1, 0, 0, 0, 0); expect_acc("R5 M via MPP=M", 0);
  endtask

  task automatic t_mprv;
    acc(2'd3, 1, 2'd1, 1, 1, 1, 1, 0); expect_acc("R6 MPRV MPP=S SUM0", 1);
    csr(2'd2, 1'b1);
    acc(2'd3, 1, 2'd1, 1, 1, 1, 1, 0); expect_acc("R6 MPRV MPP=S SUM1", 0);
    acc(2'd3, 1, 2'd0, 1, 0, 1, 1, 0); expect_acc("R6 MPRV MPP=U S page", 1);
    acc(2'd1, 1, 2'd3, 1, 1, 1, 1, 0); expect_acc("R6 MPRV ignored in S", 0);
    csr(2'd3, 1'b1);
    acc(2'd0, 1, 2'd3, 1, 0, 1, 1, 0); expect_acc("R6 MPRV ignored in U", 1);
  endtask

  task automatic t_user;
    acc(2'd0, 0, 2'd0, 1, 0, 1, 1, 0); expect_acc("R7 U on S page SUM0", 1);
    csr(2'd2, 1'b1);
    acc(2'd0, 0, 2'd0, 1, 0, 1, 1, 1); expect_acc("R7 U on S page SUM1", 1);
    acc(2'd0, 0, 2'd0, 1, 1, 1, 1, 1); expect_acc("R7 U on U page", 0);
    acc(2'd2, 0, 2'd0, 1, 0, 1, 1, 0); expect_acc("R7 reserved priv as U", 1);
    csr(2'd3, 1'b1);
  endtask

  task automatic t_rw;
    csr(2'd2, 1'b1);
    acc(2'd1, 0, 2'd0, 1, 1, 0, 1, 0); expect_acc("R8 load no R SUM1", 1);
    acc(2'd1, 0, 2'd0, 1, 1, 1, 0, 1); expect_acc("R8 store no W SUM1", 1);
    chk("R8 store cause", {59'd0, cause_a}, 64'd15);
    acc(2'd0, 0, 2'd0, 1, 1, 0, 1, 0); expect_acc("R8 U load no R", 1);
    acc(2'd0, 0, 2'd0, 1, 1, 0, 1, 1); expect_acc("R8 U store W only", 0);
    csr(2'd3, 1'b1);
  endtask

  task automatic t_idle;
    acc(2'd0, 0, 2'd0, 1, 0, 0, 0, 1);
    acc_valid = 1'b0; #1;
    chk("R9 invalid ok", {63'd0, ok_a}, 64'd0);
    chk("R9 invalid fault", {63'd0, flt_a}, 64'd0);
    chk("R9 invalid cause", {59'd0, cause_a}, 64'd0);
  endtask

  task automatic t_locked;
    csr(2'd1, 1'b1);
    chk("R10 locked after write", rd_b, 64'd0);
    chk("R10 writable copy", rd_a, 64'h40000);
    csr(2'd2, 1'b1);
    chk("R10 locked after set", rd_b, 64'd0);
    acc(2'd1, 0, 2'd0, 1, 1, 1, 1, 0);
    chk("R10 S on U page faults", {63'd0, flt_b}, 64'd1);
    chk("R10 cause", {59'd0, cause_b}, 64'd13);
    csr(2'd3, 1'b1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_csr_ops();
    t_super_sum();
    t_paging_off();
    t_machine();
    t_mprv();
    t_user();
    t_rw();
    t_idle();
    t_locked();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule